// File: doc/BRIEF.md
# Hard-Decision Viterbi Add-Compare-Select Unit

This block is the metric datapath of a hard-decision Viterbi decoder for a rate-1/2 convolutional code with constraint length 3, so its trellis has four states. On every cycle where `in_valid` is high it takes one received 2-bit symbol. It scores every trellis branch by the Hamming distance between that symbol and the branch's expected code bits. For each state it adds this score to the metric of each of the two predecessor states and keeps the smaller sum as the new path metric.

For each state the block reports one decision bit that names the predecessor that survived. It also reports the index of the state that now holds the smallest metric. A survivor memory downstream stores the decisions and traces back from the best state. Path metrics are 8 bits wide and wrap freely. Survivors are chosen from the sign bit of a wrapped difference, so the metrics never need rescaling.

Top module: `vit_acs`

## Requirements
- R1: While reset is held, and on the first cycle after it, `out_valid` is 0, `out_dec` is 4'b0000 and `out_best` is 2'b00.
- R2: `out_valid` is `in_valid` delayed by one clock. A cycle with `in_valid` low leaves `out_dec`, `out_best` and all path metrics unchanged.
- R3: A state index is {previous input, input before that}. The input u moves state {a,b} to {u,a}. The expected code bits for that branch are `in_sym[1]` = u^a^b (taps 111) and `in_sym[0]` = u^b (taps 101). The branch score is the Hamming distance from `in_sym` to the expected bits, so it is 0, 1 or 2.
- R4: Bit s of `out_dec` is 1 when the candidate through predecessor {s[0],1} is strictly smaller than the candidate through predecessor {s[0],0}. Otherwise it is 0.
- R5: When the two candidates for a state are equal, the predecessor with LSB 0 survives and the decision bit is 0.
- R6: `out_best` is the index of the smallest of the four new path metrics. When several metrics are equal and smallest, the lowest index is reported.
- R7: Reset sets the metric of state 00 to 0 and the other three metrics to 64, so decoding starts from the all-zero encoder state.
- R8: Metrics are 8-bit values that wrap modulo 256, and they are compared through the sign of their wrapped difference. Decisions and the best state stay correct after the accumulated metrics pass 255.
- R9: Outputs are registered. `out_dec` and `out_best` for an accepted symbol appear on the clock edge after the one that accepts it, together with `out_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Received symbol is present this cycle |
| in_sym | input | 2 | Received hard-decision code bits |
| out_valid | output | 1 | Decisions and best state are new this cycle |
| out_dec | output | 4 | One survivor decision bit per state |
| out_best | output | 2 | Index of the state with the smallest metric |

## Verification
The hardest condition to reach from the ports is a run in which every metric has passed 255 and wrapped. The comparison must still pick the right survivor when the stored values are numerically out of order. The stimulus reaches this state with long encoded streams carrying a high rate of injected bit errors. The bench compares each cycle against a model that uses unbounded integer metrics. Exact ties between candidates arise often under this stimulus, and these cycles are tagged separately so that the tie-break rule is checked many times.

// File: rtl/vit_acs.sv
module vit_acs #(
  parameter int PMW = 8,
  parameter int BMW = 5,
  parameter int INIT_OTHER = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic [1:0] in_sym,
  output logic       out_valid,
  output logic [3:0] out_dec,
  output logic [1:0] out_best
);
  localparam int NS = 4;

  logic [PMW-1:0] pm    [NS];
  logic [PMW-1:0] pm_nx [NS];
  logic [NS-1:0]  dec_nx;
  logic [1:0]     best_nx;

  function automatic logic [BMW-1:0] ham(input logic [1:0] a, input logic [1:0] b);
    return BMW'(a[1] ^ b[1]) + BMW'(a[0] ^ b[0]);
  endfunction

  // strict a < b under wrap-around ordering
  function automatic logic wlt(input logic [PMW-1:0] a, input logic [PMW-1:0] b);
    logic [PMW-1:0] d;
    d = a - b;
    return d[PMW-1];
  endfunction

  for (genvar s = 0; s < NS; s++) begin : g_acs
    localparam logic [1:0] ST = 2'(s);
    localparam int P0 = {ST[0], 1'b0};
    localparam int P1 = {ST[0], 1'b1};
    localparam logic [1:0] E0 = {ST[1] ^ ST[0], ST[1]};
    localparam logic [1:0] E1 = ~E0;

    logic [BMW-1:0] bm0, bm1;
    logic [PMW-1:0] c0, c1, diff;

    assign bm0  = ham(in_sym, E0);
    assign bm1  = ham(in_sym, E1);
    assign c0   = pm[P0] + PMW'(bm0);
    assign c1   = pm[P1] + PMW'(bm1);
    assign diff = c0 - c1;
    assign dec_nx[s] = ~diff[PMW-1] & (diff != '0);
    assign pm_nx[s]  = dec_nx[s] ? c1 : c0;
  end

  logic lo_sel, hi_sel, top_sel;
  assign lo_sel  = wlt(pm_nx[1], pm_nx[0]);
  assign hi_sel  = wlt(pm_nx[3], pm_nx[2]);
  assign top_sel = wlt(pm_nx[hi_sel ? 3 : 2], pm_nx[lo_sel ? 1 : 0]);
  assign best_nx = top_sel ? {1'b1, hi_sel} : {1'b0, lo_sel};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NS; i++) pm[i] <= (i == 0) ? '0 : PMW'(INIT_OTHER);
      out_valid <= 1'b0;
      out_dec   <= '0;
      out_best  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int i = 0; i < NS; i++) pm[i] <= pm_nx[i];
        out_dec  <= dec_nx;
        out_best <= best_nx;
      end
    end
  end

  logic [PMW-1:0] min_pm;
  assign min_pm = pm[out_best];

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(out_dec) && $stable(out_best) && $stable(min_pm)));
  assert_min_growth_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ((min_pm - $past(min_pm)) <= PMW'(2)));

  for (genvar s = 0; s < NS; s++) begin : g_chk
    logic [PMW-1:0] spread;
    assign spread = pm[s] - min_pm;
    assert_best_is_min_R6: assert property (@(posedge clk) disable iff (!rst_n)
      spread[PMW-1] == 1'b0);
  end
endmodule

// File: tb/sim_vit_acs.sv
module sim_vit_acs;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, in_valid;
  logic [1:0] in_sym;
  logic       out_valid;
  logic [3:0] out_dec;
  logic [1:0] out_best;

  vit_acs u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sym(in_sym),
              .out_valid(out_valid), .out_dec(out_dec), .out_best(out_best));

  int total = 0, bad = 0;
  bit done = 0;
  int m [4];
  logic [3:0] exp_dec;
  logic [1:0] exp_best;
  bit tie_seen;
  logic [1:0] enc;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hd(input logic [1:0] a, input logic [1:0] b);
    return int'(a[1] ^ b[1]) + int'(a[0] ^ b[0]);
  endfunction

  task automatic model(input logic [1:0] sy);
    int nm [4];
    int mn;
    tie_seen = 0;
    for (int s = 0; s < 4; s++) begin
      logic [1:0] st, e0;
      int c0, c1;
      st = 2'(s);
      e0 = {st[1] ^ st[0], st[1]};
      c0 = m[{st[0], 1'b0}] + hd(sy, e0);
      c1 = m[{st[0], 1'b1}] + hd(sy, ~e0);
      if (c0 == c1) tie_seen = 1;
      exp_dec[s] = (c1 < c0);
      nm[s] = (c1 < c0) ? c1 : c0;
    end
    mn = nm[0]; exp_best = 0;
    for (int s = 1; s < 4; s++) if (nm[s] < mn) begin mn = nm[s]; exp_best = 2'(s); end
    for (int s = 0; s < 4; s++) m[s] = nm[s];
  endtask

  function automatic logic [1:0] encode(input logic u);
    logic [1:0] y;
    y = {u ^ enc[1] ^ enc[0], u ^ enc[0]};
    enc = {u, enc[1]};
    return y;
  endfunction

  task automatic do_reset;
    rst_n = 1'b0; in_valid = 1'b0; in_sym = 2'b00;
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0 && out_dec == 4'd0 && out_best == 2'd0, "R1 reset outputs",
        {out_valid, out_dec, out_best}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && out_dec == 4'd0 && out_best == 2'd0, "R1 after release",
        {out_valid, out_dec, out_best}, 0);
    m[0] = 0; m[1] = 64; m[2] = 64; m[3] = 64;
    enc = 2'b00;
  endtask

  task automatic step(input bit v, input logic [1:0] sy, input string tag);
    logic [3:0] pd;
    logic [1:0] pb;
    pd = out_dec; pb = out_best;
    in_valid = v; in_sym = sy;
    @(negedge clk);
    in_valid = 1'b0;
    if (v) begin
      model(sy);
      chk(out_valid == 1'b1, "R2/R9 out_valid after accept", int'(out_valid), 1);
      chk(out_dec == exp_dec, tie_seen ? {tag, " R4 R5 decisions with tie"} : {tag, " R4 decisions"},
          int'(out_dec), int'(exp_dec));
      chk(out_best == exp_best, {tag, " R6 best state"}, int'(out_best), int'(exp_best));
      if (m[exp_best] > 255)
        chk(out_dec == exp_dec && out_best == exp_best, "R8 wrapped metrics",
            int'({out_dec, out_best}), int'({exp_dec, exp_best}));
    end else begin
      chk(out_valid == 1'b0, "R2 out_valid idle", int'(out_valid), 0);
      chk(out_dec == pd && out_best == pb, "R2 outputs held when idle",
          int'({out_dec, out_best}), int'({pd, pb}));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    do_reset();
    step(1, 2'b00, "R7 first symbol");
    chk(out_dec == 4'b0000 && out_best == 2'b00, "R7 start from state 00",
        int'({out_dec, out_best}), 0);

    // clean encoded stream: best state tracks the encoder state
    for (int i = 0; i < 40; i++) begin
      logic u;
      u = 1'($urandom_range(0, 1));
      step(1, encode(u), "R3 clean stream");
      if (i >= 2) chk(out_best == enc, "R3 best equals encoder state", int'(out_best), int'(enc));
    end

    // idle gap does not move the metrics
    step(0, 2'b11, "R2");
    step(0, 2'b10, "R2");
    step(1, encode(1'b1), "R2 after gap");

    // all-ones symbols from reset: repeated equal candidates
    do_reset();
    for (int i = 0; i < 6; i++) step(1, 2'b11, "R5 directed");

    // noisy encoded stream long enough to wrap every metric
    do_reset();
    for (int i = 0; i < 4000; i++) begin
      logic [1:0] y;
      y = encode(1'($urandom_range(0, 1)));
      if ($urandom_range(0, 99) < 35) y = y ^ 2'($urandom_range(1, 3));
      step($urandom_range(0, 9) < 8, y, "R8 noisy");
    end
    chk(m[exp_best] > 255, "R8 wrap reached", m[exp_best], 256);

    // fully random symbols after the wrap
    for (int i = 0; i < 500; i++) step(1, 2'($urandom_range(0, 3)), "R8 random");

    // reset during operation restores the start metrics
    do_reset();
    step(1, 2'b00, "R7 after re-reset");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule